// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block reaches a PHY's 16-bit internal registers, which are not mapped into any address space. The PHY exposes only one control word and one status word. The sequencer turns a single user request into a series of steps on those two words. A request is a read or a write, with a 16-bit register address and, for a write, 16-bit data. Each step changes the control word and then waits for the PHY acknowledge to reach a given level. The acknowledge must go high and then low again before the next step may begin.

Every access starts with an address-capture step. A write then has a data-capture step and a write-strobe step. A read has a read-strobe step, and the PHY register value is taken from the status word while the acknowledge is high. The acknowledge is sampled at a fixed cycle spacing, and the number of samples is limited. If the expected level does not appear in time, the access ends with an error and the control word returns to zero. A one-cycle done pulse closes every access.

Top module: `phy_indirect_master`

## Requirements
- R1: While reset is held and after it is released, the control word is zero, done and error are low, and read data is zero.
- R2: The control word carries the address or data value in bits [15:0], address-capture in bit 16, data-capture in bit 17, write strobe in bit 18 and read strobe in bit 19, and it never has more than one of bits [19:16] set. The acknowledge is status bit 16, and the read value is status bits [15:0].
- R3: Every access begins with this address phase: the address with no strobe for one cycle, then the address plus address-capture until acknowledge high, then the address alone until acknowledge low.
- R4: After the address phase, a write drives the data alone for one cycle, then data plus data-capture until acknowledge high, then the data alone until acknowledge low. It then drives the write strobe alone until acknowledge high, then the data alone until acknowledge low, and then the control word returns to zero.
- R5: After the address phase, a read drives the read strobe alone until acknowledge high and latches status [15:0]. It then drives zero until acknowledge low. The latched value appears on read data with done and holds until the next successful read.
- R6: In each wait step, the acknowledge is sampled in the step's first cycle and then every SAMPLE_GAP cycles, at most POLL_LIMIT times. When the PHY reaches the expected level L cycles into the step, the step lasts ceil(L/SAMPLE_GAP)*SAMPLE_GAP+1 cycles.
- R7: If the last allowed sample of a step does not match, done and error assert together, the control word is zero in that cycle, the PHY sees no further strobe, and read data keeps its old value.
- R8: A request is taken only when the sequencer is idle. A request presented during an access is ignored and produces no access and no done.
- R9: Done is high for exactly one cycle per accepted request, and error is never high without done.
- R10: A request presented in the cycle that done is high is accepted, so two accesses can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Acknowledge timeout, valid with done |
| rsp_rdata | output | 16 | Value from the last successful read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_status | input | 17 | Status word from the PHY, acknowledge in bit 16 |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting a new request in the same cycle in which it observes done. It then compares the second access's full record of control-word changes and its completion latency against values computed from the step timing formula. A request presented in the middle of an access is also covered: it must leave no trace in the PHY model's register contents and must produce no extra done.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;

   // Sequencer steps; order follows the access protocol
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_A_SET,
      ST_A_CAP,
      ST_A_REL,
      ST_D_SET,
      ST_D_CAP,
      ST_D_REL,
      ST_W_STB,
      ST_W_REL,
      ST_R_STB,
      ST_R_REL
   } seq_state_e;

   // Strobe positions, counted upward from the top of the value field
   localparam int STB_ACAP = 0;
   localparam int STB_DCAP = 1;
   localparam int STB_WR   = 2;
   localparam int STB_RD   = 3;
   localparam int STB_N    = 4;

endpackage

// File: rtl/phyacc_poll.sv
module phyacc_poll #(
   parameter int POLL_LIMIT = 10,
   parameter int SAMPLE_GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_en,
   input  logic ack_lvl,
   input  logic want_hi,
   output logic hit,
   output logic expire
);

   localparam int TRY_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
   localparam int GAP_W = (SAMPLE_GAP > 1) ? $clog2(SAMPLE_GAP) : 1;

   logic             sample_now;
   logic             finish;
   logic [TRY_W-1:0] tries_q;

   generate
      if (SAMPLE_GAP == 1) begin : g_every
         assign sample_now = wait_en;
      end else begin : g_spaced
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               gap_q <= '0;
            else if (!wait_en || finish)
               gap_q <= '0;
            else if (gap_q == GAP_W'(SAMPLE_GAP - 1))
               gap_q <= '0;
            else
               gap_q <= gap_q + 1'b1;
         end
         assign sample_now = wait_en && (gap_q == '0);
      end
   endgenerate

   assign hit    = sample_now && (ack_lvl == want_hi);
   assign expire = sample_now && (ack_lvl != want_hi) &&
                   (tries_q == TRY_W'(POLL_LIMIT - 1));
   assign finish = hit || expire;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tries_q <= '0;
      else if (!wait_en || finish)
         tries_q <= '0;
      else if (sample_now)
         tries_q <= tries_q + 1'b1;
   end

   // R6
   try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < TRY_W'(POLL_LIMIT));

   // R6
   wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_en |=> tries_q == '0);

endmodule

// File: rtl/phyacc_ctl_enc.sv
module phyacc_ctl_enc
   import phyacc_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  seq_state_e               state,
   input  logic [VAL_W-1:0]         addr_val,
   input  logic [VAL_W-1:0]         data_val,
   output logic [VAL_W+STB_N-1:0]   ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (state)
         ST_A_SET, ST_A_REL: ctrl[VAL_W-1:0] = addr_val;
         ST_A_CAP: begin
            ctrl[VAL_W-1:0]        = addr_val;
            ctrl[VAL_W + STB_ACAP] = 1'b1;
         end
         ST_D_SET, ST_D_REL, ST_W_REL: ctrl[VAL_W-1:0] = data_val;
         ST_D_CAP: begin
            ctrl[VAL_W-1:0]        = data_val;
            ctrl[VAL_W + STB_DCAP] = 1'b1;
         end
         ST_W_STB: ctrl[VAL_W + STB_WR] = 1'b1;
         ST_R_STB: ctrl[VAL_W + STB_RD] = 1'b1;
         default:  ctrl = '0;
      endcase
   end

endmodule

// File: rtl/phy_indirect_master.sv
module phy_indirect_master
   import phyacc_pkg::*;
#(
   parameter int VAL_W      = 16,
   parameter int POLL_LIMIT = 10,
   parameter int SAMPLE_GAP = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [VAL_W-1:0]         req_addr,
   input  logic [VAL_W-1:0]         req_wdata,
   output logic                     rsp_done,
   output logic                     rsp_error,
   output logic [VAL_W-1:0]         rsp_rdata,
   output logic [VAL_W+STB_N-1:0]   phy_ctrl,
   input  logic [VAL_W:0]           phy_status
);

   localparam int ACK_POS = VAL_W;
   localparam int CTRL_W  = VAL_W + STB_N;

   generate
      if (VAL_W < 1) begin : g_bad_width
         $error("VAL_W must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_limit
         $error("POLL_LIMIT must be at least 1");
      end
      if (SAMPLE_GAP < 1) begin : g_bad_gap
         $error("SAMPLE_GAP must be at least 1");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [VAL_W-1:0] addr_q, data_q, rdata_q;
   logic             wr_q, done_q, err_q;
   logic             wait_en, want_hi, hit, expire, finish_ok;

   always_comb begin
      wait_en = 1'b0;
      want_hi = 1'b0;
      unique case (state_q)
         ST_A_CAP, ST_D_CAP, ST_W_STB, ST_R_STB: begin
            wait_en = 1'b1;
            want_hi = 1'b1;
         end
         ST_A_REL, ST_D_REL, ST_W_REL, ST_R_REL: wait_en = 1'b1;
         default: ;
      endcase
   end

   phyacc_poll #(
      .POLL_LIMIT (POLL_LIMIT),
      .SAMPLE_GAP (SAMPLE_GAP)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .wait_en (wait_en),
      .ack_lvl (phy_status[ACK_POS]),
      .want_hi (want_hi),
      .hit     (hit),
      .expire  (expire)
   );

   phyacc_ctl_enc #(
      .VAL_W (VAL_W)
   ) u_enc (
      .state    (state_q),
      .addr_val (addr_q),
      .data_val (data_q),
      .ctrl     (phy_ctrl)
   );

   assign finish_ok = hit && (state_q == ST_W_REL || state_q == ST_R_REL);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_A_SET;
         ST_A_SET: state_d = ST_A_CAP;
         ST_A_CAP: if (hit) state_d = ST_A_REL;
         ST_A_REL: if (hit) state_d = wr_q ? ST_D_SET : ST_R_STB;
         ST_D_SET: state_d = ST_D_CAP;
         ST_D_CAP: if (hit) state_d = ST_D_REL;
         ST_D_REL: if (hit) state_d = ST_W_STB;
         ST_W_STB: if (hit) state_d = ST_W_REL;
         ST_W_REL: if (hit) state_d = ST_IDLE;
         ST_R_STB: if (hit) state_d = ST_R_REL;
         ST_R_REL: if (hit) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
      if (expire)
         state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         wr_q    <= 1'b0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish_ok || expire;
         err_q   <= expire;
         if (state_q == ST_IDLE && req_valid) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            wr_q   <= req_write;
         end
         if (state_q == ST_R_STB && hit)
            rdata_q <= phy_status[VAL_W-1:0];
      end
   end

   assign rsp_done  = done_q;
   assign rsp_error = err_q;
   assign rsp_rdata = rdata_q;

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phy_ctrl[CTRL_W-1:VAL_W]) <= 1);

   // R7
   done_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> phy_ctrl == '0);

   // R9
   error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_done);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(data_q) && $stable(wr_q)));

   // R5
   rdata_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> $past(phy_ctrl[VAL_W + STB_RD] && phy_status[ACK_POS]));

endmodule

// File: tb/phy_indirect_master_test.sv
module phy_indirect_master_test;

   localparam int G   = 4;
   localparam int LIM = 10;
   localparam int TMO = (LIM - 1) * G + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done, rsp_error;
   logic [15:0] rsp_rdata;
   logic [19:0] phy_ctrl;
   logic [16:0] phy_status;

   always #10 clk = ~clk;

   phy_indirect_master #(
      .VAL_W (16), .POLL_LIMIT (LIM), .SAMPLE_GAP (G)
   ) uut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .rsp_done (rsp_done),
      .rsp_error (rsp_error), .rsp_rdata (rsp_rdata), .phy_ctrl (phy_ctrl),
      .phy_status (phy_status)
   );

   // ---------------- PHY model ----------------
   int          lat = 0;
   logic [3:0]  deaf = '0;
   bit          stick = 1'b0;
   logic        ack = 1'b0;
   logic [15:0] rd_val = '0;
   logic [15:0] ph_addr = '0, ph_data = '0;
   logic [15:0] mem [16];
   logic [15:0] exp_mem [16];
   logic [19:0] prev = '0;
   int          age = 0;
   bit          logging = 1'b0;
   logic [19:0] log_v [16];
   int          log_n = 0;

   assign phy_status = {ack, rd_val};

   always @(negedge clk) begin
      logic want, old;
      if (!rst_n) begin
         age = 0; prev = '0; ack = 1'b0;
      end else begin
         if (phy_ctrl != prev) begin
            age = 0;
            prev = phy_ctrl;
            if (logging && log_n < 16) begin
               log_v[log_n] = phy_ctrl;
               log_n++;
            end
         end else if (age < 100000) begin
            age++;
         end
         want = |(phy_ctrl[19:16] & ~deaf);
         old  = ack;
         if (age >= lat && !(stick && ack)) ack = want;
         if (ack && !old) begin
            if (phy_ctrl[16]) ph_addr = phy_ctrl[15:0];
            if (phy_ctrl[17]) ph_data = phy_ctrl[15:0];
            if (phy_ctrl[18]) mem[ph_addr[3:0]] = ph_data;
            if (phy_ctrl[19]) rd_val = mem[ph_addr[3:0]];
         end
      end
   end

   // ---------------- checking ----------------
   int  nchk = 0, nfail = 0;
   bit  finished = 1'b0;
   logic prev_done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // R9 monitor: error only with done, done never two cycles in a row
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_error && !rsp_done) chk(1'b0, "R9", "error without done", 32'(rsp_error), 0);
         if (rsp_done && prev_done)  chk(1'b0, "R9", "done wider than one cycle", 32'(rsp_done), 0);
      end
      prev_done = rsp_done;
   end

   function automatic int wdur(input int l);
      return ((l + G - 1) / G) * G + 1;
   endfunction

   // Runs one access; starts and ends 2 ns after a falling edge
   task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input int poke_at, output int cyc, output bit err,
                         output logic [15:0] rd);
      log_n = 0; logging = 1'b1;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      cyc = 0;
      forever begin
         @(negedge clk); #2;
         cyc++;
         if (cyc == 1) req_valid = 1'b0;
         if (cyc == poke_at) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0F0F; req_wdata = 16'hDEAD;
         end else if (cyc == poke_at + 1) begin
            req_valid = 1'b0;
         end
         if (rsp_done || cyc > 3000) break;
      end
      logging = 1'b0;
      err = rsp_error; rd = rsp_rdata;
      chk(phy_ctrl == '0, "R7", "control word at done", 32'(phy_ctrl), 0);
   endtask

   task automatic chk_write_log(input string req, input logic [15:0] a, input logic [15:0] d);
      logic [19:0] e [9];
      e[0] = {4'h0, a}; e[1] = {4'h1, a}; e[2] = {4'h0, a};
      e[3] = {4'h0, d}; e[4] = {4'h2, d}; e[5] = {4'h0, d};
      e[6] = 20'h40000; e[7] = {4'h0, d}; e[8] = 20'h0;
      chk(log_n == 9, req, "write step count", 32'(log_n), 9);
      for (int i = 0; i < 9; i++)
         if (i < log_n) chk(log_v[i] == e[i], req, "write control step", 32'(log_v[i]), 32'(e[i]));
   endtask

   task automatic chk_read_log(input string req, input logic [15:0] a);
      logic [19:0] e [5];
      e[0] = {4'h0, a}; e[1] = {4'h1, a}; e[2] = {4'h0, a};
      e[3] = 20'h80000; e[4] = 20'h0;
      chk(log_n == 5, req, "read step count", 32'(log_n), 5);
      for (int i = 0; i < 5; i++)
         if (i < log_n) chk(log_v[i] == e[i], req, "read control step", 32'(log_v[i]), 32'(e[i]));
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); #2; end
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         chk(1'b0, "R9", "watchdog expired", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int cyc; bit err; logic [15:0] rd, a, d, last_rd;
      for (int i = 0; i < 16; i++) begin
         mem[i] = 16'h3C00 + 16'(i * 7);
         exp_mem[i] = 16'h3C00 + 16'(i * 7);
      end
      repeat (3) @(negedge clk);
      #2;
      // R1: reset state while held
      chk(phy_ctrl == '0, "R1", "ctrl in reset", 32'(phy_ctrl), 0);
      chk(rsp_done == 0 && rsp_error == 0, "R1", "done/error in reset", {rsp_done, rsp_error}, 0);
      rst_n = 1'b1;
      idle(2);
      chk(rsp_rdata == '0, "R1", "rdata after reset", 32'(rsp_rdata), 0);
      chk(phy_ctrl == '0 && !rsp_done, "R1", "idle after reset", 32'(phy_ctrl), 0);

      // R3 R4 R5 R6: sweep PHY latency, write then read back
      for (int l = 0; l <= 12; l++) begin
         lat = l;
         a = 16'((l + 1) * 16'h0111);
         d = 16'hC3A5 ^ 16'(l * 16'h0203);
         run_op(1'b1, a, d, -5, cyc, err, rd);
         exp_mem[a[3:0]] = d;
         chk(!err, "R4", "write error flag", 32'(err), 0);
         chk(cyc == 3 + 6 * wdur(l), "R6", "write latency", 32'(cyc), 32'(3 + 6 * wdur(l)));
         chk_write_log("R4", a, d);
         idle(1);
         run_op(1'b0, a, 16'h0, -5, cyc, err, rd);
         chk(!err, "R5", "read error flag", 32'(err), 0);
         chk(rd == exp_mem[a[3:0]], "R5", "read data", 32'(rd), 32'(exp_mem[a[3:0]]));
         chk(cyc == 2 + 4 * wdur(l), "R6", "read latency", 32'(cyc), 32'(2 + 4 * wdur(l)));
         chk_read_log("R3", a);
         idle(1);
      end
      last_rd = rd;

      // R6 boundary: acknowledge reached on the last allowed sample
      lat = (LIM - 1) * G;
      run_op(1'b0, 16'h0123, 16'h0, -5, cyc, err, rd);
      chk(!err, "R6", "last-sample read error flag", 32'(err), 0);
      chk(cyc == 2 + 4 * wdur(lat), "R6", "last-sample latency", 32'(cyc), 32'(2 + 4 * wdur(lat)));
      chk(rd == exp_mem[3], "R5", "last-sample read data", 32'(rd), 32'(exp_mem[3]));
      last_rd = rd;
      idle(2);

      // R7: one cycle too late -> timeout in address capture
      lat = (LIM - 1) * G + 1;
      run_op(1'b0, 16'h0124, 16'h0, -5, cyc, err, rd);
      chk(err, "R7", "timeout read error flag", 32'(err), 1);
      chk(cyc == 2 + TMO, "R7", "timeout read latency", 32'(cyc), 32'(2 + TMO));
      chk(rd == last_rd, "R7", "rdata kept after timeout", 32'(rd), 32'(last_rd));
      run_op(1'b1, 16'h0125, 16'h7777, -5, cyc, err, rd);
      chk(err && cyc == 2 + TMO, "R7", "timeout write", 32'(cyc), 32'(2 + TMO));
      lat = 0;
      idle(3);
      run_op(1'b0, 16'h0125, 16'h0, -5, cyc, err, rd);
      chk(rd == exp_mem[5], "R7", "register untouched by failed write", 32'(rd), 32'(exp_mem[5]));
      last_rd = rd;
      idle(2);

      // R7: PHY ignores write strobe
      deaf = 4'b0100;
      run_op(1'b1, 16'h0126, 16'h5151, -5, cyc, err, rd);
      chk(err, "R7", "ignored write strobe error", 32'(err), 1);
      chk(cyc == 3 + 4 * wdur(0) + TMO, "R7", "ignored write strobe latency", 32'(cyc), 32'(3 + 4 * wdur(0) + TMO));
      // R7: PHY ignores read strobe
      deaf = 4'b1000;
      idle(1);
      run_op(1'b0, 16'h0126, 16'h0, -5, cyc, err, rd);
      chk(err && cyc == 2 + 2 * wdur(0) + TMO, "R7", "ignored read strobe", 32'(cyc), 32'(2 + 2 * wdur(0) + TMO));
      chk(rd == last_rd, "R7", "rdata kept after read strobe timeout", 32'(rd), 32'(last_rd));
      deaf = '0;
      idle(1);
      run_op(1'b0, 16'h0126, 16'h0, -5, cyc, err, rd);
      chk(!err && rd == exp_mem[6], "R7", "write not applied", 32'(rd), 32'(exp_mem[6]));
      idle(2);

      // R7: acknowledge stuck high -> release step times out
      stick = 1'b1;
      run_op(1'b0, 16'h0127, 16'h0, -5, cyc, err, rd);
      chk(err && cyc == 3 + TMO, "R7", "stuck acknowledge", 32'(cyc), 32'(3 + TMO));
      stick = 1'b0;
      idle(3);
      chk(phy_status[16] == 1'b0, "R7", "acknowledge released", 32'(phy_status[16]), 0);

      // R8: request during an access is ignored
      lat = 2;
      run_op(1'b1, 16'h0128, 16'hA1B2, 4, cyc, err, rd);
      exp_mem[8] = 16'hA1B2;
      chk(!err && cyc == 3 + 6 * wdur(2), "R8", "access with poke", 32'(cyc), 32'(3 + 6 * wdur(2)));
      chk_write_log("R8", 16'h0128, 16'hA1B2);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #2;
         chk(!rsp_done && phy_ctrl == '0, "R8", "no access from ignored request", {rsp_done, 12'h0, phy_ctrl}, 0);
      end
      chk(mem[15] == exp_mem[15], "R8", "ignored request left register", 32'(mem[15]), 32'(exp_mem[15]));

      // R10: back-to-back, second request in the done cycle
      lat = 1;
      run_op(1'b1, 16'h0229, 16'h9ABC, -5, cyc, err, rd);
      exp_mem[9] = 16'h9ABC;
      chk(!err, "R10", "first access", 32'(err), 0);
      run_op(1'b0, 16'h0229, 16'h0, -5, cyc, err, rd);
      chk(!err && rd == 16'h9ABC, "R10", "back-to-back read data", 32'(rd), 32'h9ABC);
      chk(cyc == 2 + 4 * wdur(1), "R10", "back-to-back latency", 32'(cyc), 32'(2 + 4 * wdur(1)));
      chk_read_log("R10", 16'h0229);
      @(negedge clk); #2;
      chk(!rsp_done, "R9", "done single cycle", 32'(rsp_done), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule